// File: doc/BRIEF.md
# Two-Wire Camera Configuration Slave

This block is the configuration port of an image sensor. A host drives a two-wire serial bus (clock and open-drain data). The block samples both lines with a much faster system clock, finds start and stop conditions, and answers one 7-bit device address. The upper five bits of that address are fixed. The lowest two come from strap pins, so four sensors can share one bus.

A write message carries two data bytes after the address. The upper nibble of the first byte is a header that selects one of nine 12-bit registers. The other twelve bits are the value. Exposure and gain values are not applied at once: they are parked in shadow storage and copied to their outputs on the next frame-start pulse. Until that pulse arrives, the device refuses to acknowledge its address. A read message returns a 32-bit status word as four bytes, most significant byte first. A select bit in the second setup register switches this word between an exposure/mode summary and a white-pixel count.

Top module: `cam_twi_slave`

## Requirements
- R1: The slave acknowledges only the address byte `{5'b00100, dev_sel, rw}`. Any other address gets no acknowledge, and no register changes for the rest of that message.
- R2: In a write, the payload is `{byte1[3:0], byte2}` and the header is `byte1[7:4]`. The header selects the register: 1 setup1, 2 setup2, 14 setup3, 3 coarse exposure, 4 fine exposure, 5 gain, 8 threshold one, 9 threshold two, 10 analog control. The slave acknowledges both data bytes.
- R3: A header of 0000 or any code not listed in R2 is not acknowledged, and no register changes.
- R4: After the second data byte is acknowledged, the slave goes idle without waiting for a stop. A further byte is not acknowledged and changes nothing. A repeated start then begins a new message normally.
- R5: A write with header 3, 4 or 5 leaves its output unchanged until the next `frame_start` pulse. Those outputs change only in the cycle after `frame_start` is high.
- R6: While such a write waits for `frame_start`, the slave acknowledges no address, neither for read nor for write.
- R7: A read returns four bytes, most significant first. The word is captured when the address is acknowledged. With setup2 bit 0 clear, the word layout is:
  - bits 31:23 hold fine exposure [8:0];
  - bits 22:14 hold coarse exposure [8:0];
  - bits 13:10 hold gain [3:0];
  - bit 9 holds setup1[4] (auto exposure);
  - bit 8 holds setup1[2] (auto gain);
  - bit 7 holds the inverse of setup1[3] (black calibration active);
  - bit 6 holds setup1[1] (linear);
  - bit 5 holds setup1[0] (backlit);
  - bit 4 is 0;
  - bits 3:0 hold the `CAM_TYPE` parameter (default 5).
- R8: With setup2 bit 0 set, the read word is `{14'b0, calib_busy, white_count[16:0]}`.
- R9: After reset, setup1 reads 0x414 and every other register reads 0. Setup1 bit 10 always reads 1, whatever value is written.
- R10: `sda_pull` changes no sooner than `HOLD_CYC` clock cycles (300 ns at 200 MHz) after a falling edge of the serial clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_sel | input | 2 | Strap pins forming the two low address bits |
| scl_in | input | 1 | Serial clock line |
| sda_in | input | 1 | Serial data line as seen on the bus |
| frame_start | input | 1 | One-cycle pulse that applies pending exposure and gain values |
| calib_busy | input | 1 | Black-calibration-in-progress flag for the read word |
| white_count | input | 17 | White-pixel count for the read word |
| sda_pull | output | 1 | 1 pulls the data line low (open-drain drive) |
| setup1_q | output | 12 | Setup register 1 |
| setup2_q | output | 12 | Setup register 2 (bit 0 selects the secondary read word) |
| setup3_q | output | 12 | Setup register 3 |
| exp_coarse_q | output | 12 | Applied coarse exposure |
| exp_fine_q | output | 12 | Applied fine exposure |
| gain_q | output | 12 | Applied gain |
| thresh1_q | output | 12 | Threshold one |
| thresh2_q | output | 12 | Threshold two |
| analog_q | output | 12 | Analog control register |

## Verification
The bench drives the bus as a bit-banged host. Random writes with arbitrary headers and payloads show that every header reaches exactly its own register, since all nine outputs are compared after each message. Directed messages use a wrong strap address, header 0000, an unused header, and a third byte after a complete write. These separate a slave that decodes strictly from one that accepts loosely. Framed writes followed by reads and frame-start pulses show the difference between deferred and immediate application, and between a blocked address and an accepted one. Reads with the select bit toggled and random status inputs pin down every field of both word layouts.

// File: rtl/cam_twi_pkg.sv
package cam_twi_pkg;

  localparam logic [4:0]  ADDR_HI      = 5'b00100;
  localparam logic [11:0] SETUP1_RST   = 12'h414;
  localparam logic [11:0] SETUP1_FORCE = 12'h400;

  localparam logic [3:0] HDR_SETUP1 = 4'h1;
  localparam logic [3:0] HDR_SETUP2 = 4'h2;
  localparam logic [3:0] HDR_EXP_C  = 4'h3;
  localparam logic [3:0] HDR_EXP_F  = 4'h4;
  localparam logic [3:0] HDR_GAIN   = 4'h5;
  localparam logic [3:0] HDR_THR1   = 4'h8;
  localparam logic [3:0] HDR_THR2   = 4'h9;
  localparam logic [3:0] HDR_ANALOG = 4'hA;
  localparam logic [3:0] HDR_SETUP3 = 4'hE;

  typedef enum logic [2:0] {LK_IDLE, LK_RX, LK_ACK, LK_TX, LK_MACK} link_st_e;

  function automatic logic hdr_known(input logic [3:0] h);
    case (h)
      HDR_SETUP1, HDR_SETUP2, HDR_SETUP3, HDR_EXP_C, HDR_EXP_F,
      HDR_GAIN, HDR_THR1, HDR_THR2, HDR_ANALOG: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic hdr_framed(input logic [3:0] h);
    return (h == HDR_EXP_C) || (h == HDR_EXP_F) || (h == HDR_GAIN);
  endfunction

  function automatic logic [31:0] status_word(
    input logic        sec,
    input logic [8:0]  fine,
    input logic [8:0]  coarse,
    input logic [3:0]  gain,
    input logic [4:0]  mode,
    input logic        cal_busy,
    input logic [16:0] wcount,
    input logic [3:0]  ctype);
    if (sec) return {14'd0, cal_busy, wcount};
    return {fine, coarse, gain, mode[4], mode[2], ~mode[3], mode[1], mode[0], 1'b0, ctype};
  endfunction

endpackage

// File: rtl/twi_sync_edge.sv
module twi_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  localparam int DEPTH = 3;
  logic [DEPTH-1:0] scl_sh, sda_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[DEPTH-2:0], scl_in};
      sda_sh <= {sda_sh[DEPTH-2:0], sda_in};
    end
  end

  assign sda_q     = sda_sh[DEPTH-2];
  assign scl_rise  = scl_sh[DEPTH-2] & ~scl_sh[DEPTH-1];
  assign scl_fall  = ~scl_sh[DEPTH-2] & scl_sh[DEPTH-1];
  assign start_evt = scl_sh[DEPTH-2] & scl_sh[DEPTH-1] & sda_sh[DEPTH-1] & ~sda_sh[DEPTH-2];
  assign stop_evt  = scl_sh[DEPTH-2] & scl_sh[DEPTH-1] & ~sda_sh[DEPTH-1] & sda_sh[DEPTH-2];
endmodule

// File: rtl/twi_link.sv
module twi_link
  import cam_twi_pkg::*;
#(
  parameter int HOLD_CYC = 60
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_rise,
  input  logic        scl_fall,
  input  logic        start_evt,
  input  logic        stop_evt,
  input  logic        sda_q,
  input  logic [6:0]  dev_addr,
  input  logic        busy,
  input  logic [31:0] rd_word,
  output logic        sda_low,
  output logic        addr_hit,
  output logic [7:0]  rx_byte,
  output logic        wr_stb,
  output logic [3:0]  wr_hdr,
  output logic [11:0] wr_data
);
  localparam int HW = $clog2(HOLD_CYC + 1);

  link_st_e      st;
  logic [3:0]    bitc;
  logic [7:0]    sh, hdr_byte;
  logic [1:0]    rxn;
  logic [2:0]    txn;
  logic          rd_mode, mack_ok, want_low;
  logic [31:0]   txw;
  logic [HW-1:0] hcnt;

  assign want_low = (st == LK_ACK) || (st == LK_TX && !sh[7]);
  assign rx_byte  = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= LK_IDLE; bitc <= '0; sh <= '0; hdr_byte <= '0; rxn <= '0; txn <= '0;
      rd_mode <= 1'b0; mack_ok <= 1'b0; txw <= '0;
      addr_hit <= 1'b0; wr_stb <= 1'b0; wr_hdr <= '0; wr_data <= '0;
    end else begin
      addr_hit <= 1'b0;
      wr_stb   <= 1'b0;
      if (start_evt) begin
        st <= LK_RX; bitc <= '0; rxn <= '0; rd_mode <= 1'b0;
      end else if (stop_evt) begin
        st <= LK_IDLE;
      end else begin
        case (st)
          LK_RX: begin
            if (scl_rise && bitc != 4'd8) begin
              sh   <= {sh[6:0], sda_q};
              bitc <= bitc + 4'd1;
            end else if (scl_fall && bitc == 4'd8) begin
              rxn <= rxn + 2'd1;
              case (rxn)
                2'd0: begin
                  if (sh[7:1] == dev_addr && !busy) begin
                    st <= LK_ACK; rd_mode <= sh[0]; addr_hit <= 1'b1; txw <= rd_word;
                  end else st <= LK_IDLE;
                end
                2'd1: begin
                  if (hdr_known(sh[7:4])) begin
                    hdr_byte <= sh; st <= LK_ACK;
                  end else st <= LK_IDLE;
                end
                default: begin
                  wr_stb  <= 1'b1;
                  wr_hdr  <= hdr_byte[7:4];
                  wr_data <= {hdr_byte[3:0], sh};
                  st      <= LK_ACK;
                end
              endcase
            end
          end
          LK_ACK: if (scl_fall) begin
            bitc <= '0;
            if (rd_mode) begin
              st <= LK_TX; sh <= txw[31:24]; txw <= {txw[23:0], 8'h00}; txn <= 3'd1;
            end else if (rxn == 2'd3) st <= LK_IDLE;
            else st <= LK_RX;
          end
          LK_TX: if (scl_fall) begin
            if (bitc == 4'd7) begin
              st <= LK_MACK; bitc <= '0;
            end else begin
              sh <= {sh[6:0], 1'b1}; bitc <= bitc + 4'd1;
            end
          end
          LK_MACK: begin
            if (scl_rise) mack_ok <= ~sda_q;
            else if (scl_fall) begin
              if (mack_ok && txn != 3'd4) begin
                st <= LK_TX; sh <= txw[31:24]; txw <= {txw[23:0], 8'h00}; txn <= txn + 3'd1;
              end else st <= LK_IDLE;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // data line drive follows the protocol state only after the hold window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0; sda_low <= 1'b0;
    end else if (scl_fall) begin
      hcnt <= HW'(HOLD_CYC);
    end else if (hcnt != '0) begin
      hcnt <= hcnt - 1'b1;
    end else begin
      sda_low <= want_low;
    end
  end
endmodule

// File: rtl/cam_cfg_regs.sv
module cam_cfg_regs
  import cam_twi_pkg::*;
#(
  parameter logic [3:0] CAM_TYPE = 4'h5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_stb,
  input  logic [3:0]  wr_hdr,
  input  logic [11:0] wr_data,
  input  logic        frame_start,
  input  logic        calib_busy,
  input  logic [16:0] white_count,
  output logic        pend,
  output logic [31:0] rd_word,
  output logic [11:0] setup1_q,
  output logic [11:0] setup2_q,
  output logic [11:0] setup3_q,
  output logic [11:0] exp_coarse_q,
  output logic [11:0] exp_fine_q,
  output logic [11:0] gain_q,
  output logic [11:0] thresh1_q,
  output logic [11:0] thresh2_q,
  output logic [11:0] analog_q
);
  logic [3:0]  sh_hdr;
  logic [11:0] sh_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      setup1_q <= SETUP1_RST; setup2_q <= '0; setup3_q <= '0;
      exp_coarse_q <= '0; exp_fine_q <= '0; gain_q <= '0;
      thresh1_q <= '0; thresh2_q <= '0; analog_q <= '0;
      sh_hdr <= '0; sh_val <= '0; pend <= 1'b0;
    end else begin
      if (frame_start && pend) begin
        pend <= 1'b0;
        case (sh_hdr)
          HDR_EXP_C: exp_coarse_q <= sh_val;
          HDR_EXP_F: exp_fine_q   <= sh_val;
          default:   gain_q       <= sh_val;
        endcase
      end
      if (wr_stb) begin
        if (hdr_framed(wr_hdr)) begin
          sh_hdr <= wr_hdr; sh_val <= wr_data; pend <= 1'b1;
        end else begin
          case (wr_hdr)
            HDR_SETUP1: setup1_q  <= wr_data | SETUP1_FORCE;
            HDR_SETUP2: setup2_q  <= wr_data;
            HDR_SETUP3: setup3_q  <= wr_data;
            HDR_THR1:   thresh1_q <= wr_data;
            HDR_THR2:   thresh2_q <= wr_data;
            HDR_ANALOG: analog_q  <= wr_data;
            default: ;
          endcase
        end
      end
    end
  end

  assign rd_word = status_word(setup2_q[0], exp_fine_q[8:0], exp_coarse_q[8:0], gain_q[3:0],
                               setup1_q[4:0], calib_busy, white_count, CAM_TYPE);
endmodule

// File: rtl/cam_twi_slave.sv
module cam_twi_slave
  import cam_twi_pkg::*;
#(
  parameter int         HOLD_CYC = 60,
  parameter logic [3:0] CAM_TYPE = 4'h5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  dev_sel,
  input  logic        scl_in,
  input  logic        sda_in,
  input  logic        frame_start,
  input  logic        calib_busy,
  input  logic [16:0] white_count,
  output logic        sda_pull,
  output logic [11:0] setup1_q,
  output logic [11:0] setup2_q,
  output logic [11:0] setup3_q,
  output logic [11:0] exp_coarse_q,
  output logic [11:0] exp_fine_q,
  output logic [11:0] gain_q,
  output logic [11:0] thresh1_q,
  output logic [11:0] thresh2_q,
  output logic [11:0] analog_q
);
  logic        sda_q_w, scl_rise_w, scl_fall_w, start_w, stop_w;
  logic        pend_w, addr_hit_w, wr_stb_w;
  logic [7:0]  rx_byte_w;
  logic [3:0]  wr_hdr_w;
  logic [11:0] wr_data_w;
  logic [31:0] rd_word_w;

  twi_sync_edge u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_q(sda_q_w), .scl_rise(scl_rise_w), .scl_fall(scl_fall_w),
    .start_evt(start_w), .stop_evt(stop_w));

  twi_link #(.HOLD_CYC(HOLD_CYC)) u_link (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise_w), .scl_fall(scl_fall_w),
    .start_evt(start_w), .stop_evt(stop_w), .sda_q(sda_q_w),
    .dev_addr({ADDR_HI, dev_sel}), .busy(pend_w), .rd_word(rd_word_w),
    .sda_low(sda_pull), .addr_hit(addr_hit_w), .rx_byte(rx_byte_w),
    .wr_stb(wr_stb_w), .wr_hdr(wr_hdr_w), .wr_data(wr_data_w));

  cam_cfg_regs #(.CAM_TYPE(CAM_TYPE)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb_w), .wr_hdr(wr_hdr_w), .wr_data(wr_data_w),
    .frame_start(frame_start), .calib_busy(calib_busy), .white_count(white_count),
    .pend(pend_w), .rd_word(rd_word_w),
    .setup1_q(setup1_q), .setup2_q(setup2_q), .setup3_q(setup3_q),
    .exp_coarse_q(exp_coarse_q), .exp_fine_q(exp_fine_q), .gain_q(gain_q),
    .thresh1_q(thresh1_q), .thresh2_q(thresh2_q), .analog_q(analog_q));
endmodule

// File: rtl/cam_twi_chk.sv
module cam_twi_chk
  import cam_twi_pkg::*;
#(
  parameter int HOLD_CYC = 60
) (
  input logic        clk,
  input logic        rst_n,
  input logic        sda_pull,
  input logic        scl_fall,
  input logic        addr_hit,
  input logic [7:0]  rx_byte,
  input logic [1:0]  dev_sel,
  input logic        pend,
  input logic        wr_stb,
  input logic [3:0]  wr_hdr,
  input logic        frame_start,
  input logic [11:0] exp_coarse_q,
  input logic [11:0] exp_fine_q,
  input logic [11:0] gain_q,
  input logic [11:0] setup1_q
);
  localparam int CW = $clog2(HOLD_CYC + 2);
  logic [CW-1:0] since_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_fall <= '0;
    else if (scl_fall) since_fall <= '0;
    else if (since_fall != CW'(HOLD_CYC + 1)) since_fall <= since_fall + 1'b1;
  end

  // R10
  hold_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> (int'(since_fall) >= HOLD_CYC));

  // R1
  addr_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |-> (rx_byte[7:1] == {ADDR_HI, dev_sel}));

  // R6
  busy_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_hit |-> !pend);

  // R3
  known_header_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> hdr_known(wr_hdr));

  // R5
  framed_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> ($stable(exp_coarse_q) && $stable(exp_fine_q) && $stable(gain_q)));

  // R9
  setup1_bit10_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup1_q[10]);
endmodule

bind cam_twi_slave cam_twi_chk #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sda_pull(sda_pull), .scl_fall(scl_fall_w),
  .addr_hit(addr_hit_w), .rx_byte(rx_byte_w), .dev_sel(dev_sel), .pend(pend_w),
  .wr_stb(wr_stb_w), .wr_hdr(wr_hdr_w), .frame_start(frame_start),
  .exp_coarse_q(exp_coarse_q), .exp_fine_q(exp_fine_q), .gain_q(gain_q),
  .setup1_q(setup1_q));

// File: tb/cam_twi_slave_test.sv
`timescale 1ns/1ps
module cam_twi_slave_test;
  localparam int HOLD = 60;
  localparam int H = 80;
  localparam logic [1:0] SEL = 2'b10;
  localparam logic [3:0] CTYPE = 4'h5;
  localparam logic [3:0] VH [9] = '{4'h1, 4'h2, 4'h3, 4'h4, 4'h5, 4'h8, 4'h9, 4'hA, 4'hE};

  logic clk = 0, rst_n = 0;
  logic scl_m = 1, sda_m = 1, frame_start = 0, calib_busy = 0;
  logic [16:0] white_count = '0;
  logic [1:0] dev_sel = SEL;
  logic sda_pull;
  logic [11:0] setup1_q, setup2_q, setup3_q, exp_coarse_q, exp_fine_q, gain_q;
  logic [11:0] thresh1_q, thresh2_q, analog_q;
  wire sda_line = sda_m & ~sda_pull;

  int nchk = 0, nerr = 0, nviol = 0, nchg = 0, since = 0;
  bit done = 0;
  logic scl_prev = 1, pull_prev = 0;
  logic [11:0] m [16];

  always #2.5 clk = ~clk;

  cam_twi_slave uut (
    .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .scl_in(scl_m), .sda_in(sda_line),
    .frame_start(frame_start), .calib_busy(calib_busy), .white_count(white_count),
    .sda_pull(sda_pull), .setup1_q(setup1_q), .setup2_q(setup2_q), .setup3_q(setup3_q),
    .exp_coarse_q(exp_coarse_q), .exp_fine_q(exp_fine_q), .gain_q(gain_q),
    .thresh1_q(thresh1_q), .thresh2_q(thresh2_q), .analog_q(analog_q));

  // hold monitor for R10: cycles from host clock fall to any change of the slave drive
  always @(negedge clk) begin
    if (scl_prev && !scl_m) since = 0; else since = since + 1;
    if (sda_pull !== pull_prev) begin
      nchg++;
      if (since < HOLD) nviol++;
    end
    scl_prev = scl_m;
    pull_prev = sda_pull;
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1; wclk(H/2); scl_m = 1; wclk(H); sda_m = 0; wclk(H); scl_m = 0; wclk(H/2);
  endtask

  task automatic bus_stop();
    sda_m = 0; wclk(H/2); scl_m = 1; wclk(H); sda_m = 1; wclk(H);
  endtask

  task automatic clk_bit(input logic b, output logic r);
    sda_m = b; wclk(H/2); scl_m = 1; wclk(H/2); r = sda_line; wclk(H/2); scl_m = 0; wclk(H/2);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], r);
    clk_bit(1'b1, r);
    ack = ~r;
  endtask

  task automatic get_byte(input logic last, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, r); b[i] = r; end
    clk_bit(last, r);
  endtask

  task automatic do_write(input logic [1:0] sel, input logic [3:0] h, input logic [11:0] d,
                          output logic a0, output logic a1, output logic a2);
    a1 = 0; a2 = 0;
    bus_start();
    put_byte({5'b00100, sel, 1'b0}, a0);
    if (a0) put_byte({h, d[11:8]}, a1);
    if (a1) put_byte(d[7:0], a2);
    bus_stop();
  endtask

  task automatic do_read(output logic a0, output logic [31:0] w);
    logic [7:0] b;
    w = '0;
    bus_start();
    put_byte({5'b00100, SEL, 1'b1}, a0);
    if (a0) for (int k = 0; k < 4; k++) begin
      get_byte(k == 3, b);
      w = {w[23:0], b};
    end
    bus_stop();
  endtask

  function automatic logic [11:0] dut_reg(input logic [3:0] h);
    case (h)
      4'h1: return setup1_q;   4'h2: return setup2_q;  4'hE: return setup3_q;
      4'h3: return exp_coarse_q; 4'h4: return exp_fine_q; 4'h5: return gain_q;
      4'h8: return thresh1_q;  4'h9: return thresh2_q; default: return analog_q;
    endcase
  endfunction

  function automatic logic [31:0] model_word();
    logic [31:0] w;
    w = '0;
    if (m[2][0]) begin
      w[16:0] = white_count; w[17] = calib_busy;
    end else begin
      w[3:0] = CTYPE; w[5] = m[1][0]; w[6] = m[1][1]; w[7] = ~m[1][3];
      w[8] = m[1][2]; w[9] = m[1][4]; w[13:10] = m[5][3:0];
      w[22:14] = m[3][8:0]; w[31:23] = m[4][8:0];
    end
    return w;
  endfunction

  task automatic check_regs(input string tag);
    for (int i = 0; i < 9; i++) chk(tag, {20'd0, dut_reg(VH[i])}, {20'd0, m[VH[i]]});
  endtask

  task automatic pulse_frame();
    frame_start = 1; wclk(1); frame_start = 0; wclk(2);
  endtask

  task automatic read_check(input string tag);
    logic a; logic [31:0] w;
    calib_busy = 1'($urandom); white_count = 17'($urandom);
    do_read(a, w);
    chk({tag, " read ack"}, {31'd0, a}, 32'd1);
    chk({tag, " word"}, w, model_word());
  endtask

  initial begin
    logic a0, a1, a2, a3;
    logic [31:0] w;
    void'($urandom(32'h5A17));
    for (int i = 0; i < 16; i++) m[i] = '0;
    m[1] = 12'h414;
    wclk(5); rst_n = 1; wclk(5);

    // R9 reset state
    chk("R9 reset pull", {31'd0, sda_pull}, 32'd0);
    check_regs("R9 reset regs");

    // R2 directed write
    do_write(SEL, 4'h2, 12'hABC, a0, a1, a2);
    m[2] = 12'hABC;
    chk("R2 acks", {29'd0, a0, a1, a2}, 32'd7);
    check_regs("R2 setup2");

    // R1 wrong strap address
    do_write(2'b01, 4'h8, 12'h777, a0, a1, a2);
    chk("R1 wrong addr nack", {31'd0, a0}, 32'd0);
    check_regs("R1 no change");

    // R3 invalid headers
    do_write(SEL, 4'h0, 12'h0FF, a0, a1, a2);
    chk("R3 hdr0 nack", {30'd0, a0, a1}, 32'd2);
    do_write(SEL, 4'h7, 12'h5AA, a0, a1, a2);
    chk("R3 hdr7 nack", {30'd0, a0, a1}, 32'd2);
    check_regs("R3 no change");

    // R4 self-idle after two data bytes, extra byte ignored, repeated start works
    bus_start();
    put_byte({5'b00100, SEL, 1'b0}, a0);
    put_byte(8'h91, a1);
    put_byte(8'h23, a2);
    m[9] = 12'h123;
    put_byte(8'h8F, a3);
    chk("R4 third byte nack", {31'd0, a3}, 32'd0);
    check_regs("R4 after extra byte");
    bus_start();
    put_byte({5'b00100, SEL, 1'b0}, a0);
    put_byte(8'h84, a1);
    put_byte(8'h56, a2);
    bus_stop();
    m[8] = 12'h456;
    chk("R4 repeated start acks", {29'd0, a0, a1, a2}, 32'd7);
    check_regs("R4 regs");

    // R5 and R6 framed write
    do_write(SEL, 4'h3, 12'h1FF, a0, a1, a2);
    chk("R5 framed acks", {29'd0, a0, a1, a2}, 32'd7);
    check_regs("R5 not yet applied");
    do_read(a0, w);
    chk("R6 read blocked", {31'd0, a0}, 32'd0);
    do_write(SEL, 4'h8, 12'h999, a0, a1, a2);
    chk("R6 write blocked", {31'd0, a0}, 32'd0);
    pulse_frame();
    m[3] = 12'h1FF;
    check_regs("R5 applied");

    // R7 primary word
    do_write(SEL, 4'h2, 12'hABC & 12'hFFE, a0, a1, a2);
    m[2] = 12'hABC & 12'hFFE;
    do_write(SEL, 4'h1, 12'h00B, a0, a1, a2);
    m[1] = 12'h40B;
    read_check("R7 primary");
    chk("R9 bit10 forced", {20'd0, setup1_q}, 32'h40B);

    // R8 secondary word
    do_write(SEL, 4'h2, 12'h001, a0, a1, a2);
    m[2] = 12'h001;
    read_check("R8 secondary");

    // random writes with reads (R2 R5 R7 R8)
    for (int it = 0; it < 8; it++) begin
      logic [3:0] h; logic [11:0] d;
      h = VH[$urandom_range(0, 8)];
      d = 12'($urandom);
      do_write(SEL, h, d, a0, a1, a2);
      chk("R2 random acks", {29'd0, a0, a1, a2}, 32'd7);
      if (h == 4'h3 || h == 4'h4 || h == 4'h5) begin
        check_regs("R5 random held");
        pulse_frame();
      end
      m[h] = (h == 4'h1) ? (d | 12'h400) : d;
      check_regs("R2 random regs");
      if (it % 3 == 2) read_check("R7 R8 random");
    end

    // R10 hold after clock fall
    chk("R10 drive changes seen", {31'd0, nchg > 0}, 32'd1);
    chk("R10 hold violations", nviol, 32'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule